// File: doc/BRIEF.md
# Event-Triggered Counter Capture Unit

This unit snapshots a free-running timebase counter at the instant a chosen compare event fires. Once a snapshot is taken, the unit locks itself out so that later events in the same period cannot overwrite it. It re-arms in one of two ways. In alignment mode, it re-arms on the next alignment pulse, which marks a zero or period match of the timebase. In software mode, it re-arms only when the capture-status flag is cleared through a strobe.

Software sees the captured value on a single read port. With shadowing disabled, the read port shows the live capture register. With shadowing enabled, the live register is copied into a shadow register on every alignment pulse, and the read port shows that copy instead. The read port therefore holds steady for a whole period, no matter when inside that period a capture lands.

Top module: `event_cnt_capture`

## Requirements
- R1: When `cap_en` is 1 and the unit is armed, a high `trig_evt` at a rising clock edge loads `cnt_in` into the capture register. The new value is visible through `rd_val` from the following cycle on.
- R2: When `shadow_en` was 0 at the latest clock edge, `rd_val` equals the capture register.
- R3: On every alignment pulse, the capture register is copied into the shadow register. When `shadow_en` was 1 at the latest clock edge, `rd_val` equals the shadow register.
- R4: After a capture, the unit is locked. Every further `trig_evt` leaves the capture register unchanged until the re-arm condition is met.
- R5: `cap_flag` goes to 1 on each capture. It returns to 0 on a `flag_clr` strobe in a cycle that has no capture.
- R6: With `rearm_sel` = 0 (alignment mode), the first `align_pulse` after a capture re-arms the unit. `flag_clr` does not re-arm it.
- R7: With `rearm_sel` = 1 (software mode), only `flag_clr` re-arms the unit. `align_pulse` does not.
- R8: When a capture and `flag_clr` happen in the same cycle, the capture wins. `cap_flag` stays 1 and the unit stays locked.
- R9: When `align_pulse` and an accepted capture happen in the same cycle, the shadow register receives the value the capture register held before that cycle, and the new capture is still taken.
- R10: While `rst` is high, both registers, `rd_val` and `cap_flag` are 0, and the unit is armed.
- R11: While `cap_en` is 0, `trig_evt` has no effect. There is no capture, no flag change and no lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | CNT_W | Timebase counter value |
| trig_evt | input | 1 | Selected, possibly filtered, compare event |
| align_pulse | input | 1 | Zero and/or period-match pulse |
| cap_en | input | 1 | Capture enable |
| shadow_en | input | 1 | Read the shadow copy instead of the live register |
| rearm_sel | input | 1 | Re-arm source: 0 = alignment pulse, 1 = flag clear |
| flag_clr | input | 1 | Strobe that clears the capture-status flag |
| rd_val | output | CNT_W | Registered readback value |
| cap_flag | output | 1 | Capture-status flag |

## Verification
The bench targets the collisions between these inputs.

- **Capture and clear in the same cycle.** If the clear is allowed to win, the flag drops and the unit re-arms with a fresh capture pending.
- **Alignment pulse and capture in the same cycle.** If the shadow is loaded from the new value, it shows a capture from the current period one period early.
- **Wrong re-arm source.** A unit that re-arms on the wrong source in either mode overwrites a locked value when a later event arrives.
- **Events while capture is disabled.** A unit that leaks these sets the flag or locks itself out with no capture having been requested.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
  typedef enum logic {
    REARM_ON_ALIGN = 1'b0,
    REARM_ON_CLEAR = 1'b1
  } rearm_e;
endpackage

// File: rtl/ccap_arm_ctl.sv
module ccap_arm_ctl
  import ccap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_evt,
  input  logic cap_en,
  input  logic align_pulse,
  input  logic flag_clr,
  input  logic rearm_sel,
  output logic take,
  output logic armed_q,
  output logic flag_q
);
  rearm_e mode;
  logic   rearm_hit;

  always_comb begin
    mode      = rearm_e'(rearm_sel);
    take      = trig_evt & cap_en & armed_q;
    rearm_hit = (mode == REARM_ON_ALIGN) ? align_pulse : flag_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (take)           flag_q <= 1'b1;
      else if (flag_clr)  flag_q <= 1'b0;

      if (take)           armed_q <= 1'b0;
      else if (rearm_hit) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ccap_hold_regs.sv
module ccap_hold_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             align_pulse,
  input  logic             shadow_en,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] act_q,
  output logic [CNT_W-1:0] shd_q,
  output logic [CNT_W-1:0] rd_q
);
  logic [CNT_W-1:0] act_d, shd_d;

  always_comb begin
    act_d = take ? cnt_in : act_q;
    shd_d = align_pulse ? act_q : shd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      shd_q <= '0;
      rd_q  <= '0;
    end else begin
      act_q <= act_d;
      shd_q <= shd_d;
      rd_q  <= shadow_en ? shd_d : act_d;
    end
  end
endmodule

// File: rtl/event_cnt_capture.sv
module event_cnt_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             trig_evt,
  input  logic             align_pulse,
  input  logic             cap_en,
  input  logic             shadow_en,
  input  logic             rearm_sel,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] rd_val,
  output logic             cap_flag
);
  logic             take_w;
  logic             arm_q;
  logic [CNT_W-1:0] act_q, shd_q;

  ccap_arm_ctl u_arm (
    .clk(clk), .rst(rst), .trig_evt(trig_evt), .cap_en(cap_en),
    .align_pulse(align_pulse), .flag_clr(flag_clr), .rearm_sel(rearm_sel),
    .take(take_w), .armed_q(arm_q), .flag_q(cap_flag)
  );

  ccap_hold_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .take(take_w), .align_pulse(align_pulse),
    .shadow_en(shadow_en), .cnt_in(cnt_in),
    .act_q(act_q), .shd_q(shd_q), .rd_q(rd_val)
  );
endmodule

// File: rtl/ccap_chk.sv
module ccap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_in,
  input logic             trig_evt,
  input logic             align_pulse,
  input logic             cap_en,
  input logic             shadow_en,
  input logic             rearm_sel,
  input logic             flag_clr,
  input logic [CNT_W-1:0] rd_val,
  input logic             cap_flag,
  input logic             armed,
  input logic [CNT_W-1:0] act,
  input logic [CNT_W-1:0] shd
);
  a_r1_capture_loads: assert property (@(posedge clk) disable iff (rst)
    (cap_en && trig_evt && armed) |=> act == $past(cnt_in));
  a_r2_read_live: assert property (@(posedge clk) disable iff (rst)
    !shadow_en |=> rd_val == act);
  a_r3_shadow_copy: assert property (@(posedge clk) disable iff (rst)
    align_pulse |=> shd == $past(act));
  a_r3_read_shadow: assert property (@(posedge clk) disable iff (rst)
    shadow_en |=> rd_val == shd);
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst)
    !armed |=> $stable(act));
  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    (cap_en && trig_evt && armed) |=> cap_flag && !armed);
  a_r6_align_rearm: assert property (@(posedge clk) disable iff (rst)
    (!armed && !rearm_sel && align_pulse) |=> armed);
  a_r7_clear_rearm: assert property (@(posedge clk) disable iff (rst)
    (!armed && rearm_sel && flag_clr) |=> armed);
  a_r7_no_align_rearm: assert property (@(posedge clk) disable iff (rst)
    (!armed && rearm_sel && !flag_clr) |=> !armed);
  a_r8_capture_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (cap_en && trig_evt && armed && flag_clr) |=> cap_flag && !armed);
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> armed && !cap_flag && rd_val == '0 && act == '0 && shd == '0);
  a_r11_disabled_ignore: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !flag_clr) |=> $stable(act) && $stable(cap_flag));
endmodule

bind event_cnt_capture ccap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_in(cnt_in), .trig_evt(trig_evt),
  .align_pulse(align_pulse), .cap_en(cap_en), .shadow_en(shadow_en),
  .rearm_sel(rearm_sel), .flag_clr(flag_clr), .rd_val(rd_val),
  .cap_flag(cap_flag), .armed(arm_q), .act(act_q), .shd(shd_q)
);

// File: tb/tb_event_cnt_capture.sv
`timescale 1ns/1ps
module tb_event_cnt_capture;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] cnt_in = '0;
  logic trig_evt = 0, align_pulse = 0, cap_en = 0, shadow_en = 0;
  logic rearm_sel = 0, flag_clr = 0;
  logic [W-1:0] rd_val;
  logic cap_flag;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R10";

  // behavioural reference
  int m_act = 0, m_shd = 0, m_rd = 0;
  bit m_armed = 1, m_flag = 0;

  always #10 clk = ~clk;

  event_cnt_capture #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .trig_evt(trig_evt),
    .align_pulse(align_pulse), .cap_en(cap_en), .shadow_en(shadow_en),
    .rearm_sel(rearm_sel), .flag_clr(flag_clr),
    .rd_val(rd_val), .cap_flag(cap_flag)
  );

  always @(posedge clk) begin
    bit hit, rearm;
    int old_act;
    if (rst) begin
      m_act = 0; m_shd = 0; m_rd = 0; m_armed = 1; m_flag = 0;
    end else begin
      hit = cap_en && trig_evt && m_armed;
      old_act = m_act;
      if (align_pulse) m_shd = old_act;
      if (hit) m_act = int'(cnt_in);
      rearm = rearm_sel ? flag_clr : align_pulse;
      if (hit) begin m_flag = 1; m_armed = 0; end
      else begin
        if (flag_clr) m_flag = 0;
        if (rearm) m_armed = 1;
      end
      m_rd = shadow_en ? m_shd : m_act;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cnt_in <= cnt_in + 16'd37;
      n_cmp++;
      if (int'(rd_val) != m_rd) begin
        n_bad++;
        $display("FAIL %s rd_val actual=%0d expected=%0d", tag, rd_val, m_rd);
      end
      n_cmp++;
      if (cap_flag != m_flag) begin
        n_bad++;
        $display("FAIL %s cap_flag actual=%0d expected=%0d", tag, cap_flag, m_flag);
      end
    end
  end

  task automatic tick(input bit ev, input bit al, input bit clr);
    @(negedge clk);
    trig_evt = ev; align_pulse = al; flag_clr = clr;
    @(negedge clk);
    trig_evt = 0; align_pulse = 0; flag_clr = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    tag = "R10"; repeat (3) @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);
    tag = "R11"; tick(1, 0, 0); tick(1, 0, 0);
    cap_en = 1;
    tag = "R1";  tick(1, 0, 0);
    tag = "R4";  tick(1, 0, 0); tick(1, 0, 1);
    tag = "R6";  tick(0, 1, 0); tick(1, 0, 0);
    tag = "R2";  tick(0, 0, 0);
    rearm_sel = 1;
    tag = "R7";  tick(0, 1, 0); tick(1, 0, 0); tick(0, 0, 1); tick(1, 0, 0);
    tag = "R8";  tick(0, 0, 1); tick(1, 0, 1); tick(1, 0, 0);
    tag = "R5";  tick(0, 0, 1); tick(0, 0, 0);
    shadow_en = 1;
    tag = "R3";  tick(0, 1, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 1, 0);
    tag = "R9";  tick(0, 0, 1); tick(1, 1, 0); tick(0, 1, 0);
    rearm_sel = 0;
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      trig_evt    = ($urandom_range(0, 3) == 0);
      align_pulse = ($urandom_range(0, 7) == 0);
      flag_clr    = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 63) == 0) cap_en    = ~cap_en;
      if ($urandom_range(0, 63) == 0) shadow_en = ~shadow_en;
      if ($urandom_range(0, 63) == 0) rearm_sel = ~rearm_sel;
    end
    @(negedge clk);
    trig_evt = 0; align_pulse = 0; flag_clr = 0;
    tag = "R10"; rst = 1; repeat (2) @(negedge clk);
    rst = 0; repeat (2) @(negedge clk);
    finish_up();
  end
endmodule